// File: doc/BRIEF.md
# 16 kbit/s Sub-Slot Switch

This block carries a 2-bit D-channel field between one time slot of a line-side serial interface and a 2-bit sub-slot inside an 8-bit time slot of a PCM highway. It serves one switched channel in each direction, which lets the D-channel traffic of a line port be handled by a central processing unit on the highway. Each direction has a 4-bit switching code and a PCM slot pointer. The code selects the bit pair inside the PCM byte. The line side always uses bits 7..6. The host loads the settings, and the framing logic supplies the slot indices, so both arrive here as plain inputs.

The downstream path has three states. `DN_UNASG` drives idle ones. `DN_SWITCH` forwards the captured pair. `DN_HIZ` releases the D bits. The upstream path has two states. `UP_UNASG` passes PCM bytes through unchanged. `UP_SWITCH` inserts the line-side pair. Each frame-start pulse is the only transition: both state registers, with their pointers and sub-slot selects, reload from the code inputs. All other cycles hold the current state.

Top module: `subslot_switch`

## Requirements
- R1: After reset both paths are unassigned: `dn_line_byte` is 8'hFF, `dn_oe` is 1 and `pcm_up_out_vld` is 0.
- R2: With downstream code 4'b01xx, the PCM bit pair chosen by the code's two low bits (11→7..6, 10→5..4, 01→3..2, 00→1..0) appears in `dn_line_byte[7:6]`. This happens from the cycle after it is captured. Bits 5..0 read 1 and `dn_oe` is 1.
- R3: Downstream capture happens only on a valid PCM byte whose slot equals the latched pointer. Bytes in other slots leave the line output unchanged.
- R4: Downstream code 4'b1011 sets `dn_oe` to 0 from the cycle after the frame start that latched it.
- R5: Any other downstream code is unassigned: `dn_oe` is 1 and `dn_line_byte` is 8'hFF.
- R6: Each valid upstream PCM byte leaves on `pcm_up_out` one cycle later, with `pcm_up_out_vld` high. In switching state (code 4'b01xx, same position map as R2), a byte in the pointed slot gets the last captured line pair in the selected position. The other six bits, and all bytes of other slots, stay unchanged.
- R7: Upstream code 4'b0000 or any code other than 4'b01xx passes every PCM byte through unchanged.
- R8: Codes and pointers take effect only at a `frm_start` pulse. Changes to them between pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Frame boundary pulse; latches codes and pointers |
| dn_code | input | 4 | Downstream switching code |
| dn_ptr | input | SLOT_W | Downstream PCM slot pointer |
| up_code | input | 4 | Upstream switching code |
| up_ptr | input | SLOT_W | Upstream PCM slot pointer |
| pcm_dn_vld | input | 1 | Downstream PCM byte valid |
| pcm_dn_slot | input | SLOT_W | Slot index of downstream PCM byte |
| pcm_dn_byte | input | 8 | Downstream PCM byte |
| dn_line_byte | output | 8 | Line-side slot, D bits in 7..6 |
| dn_oe | output | 1 | Output enable of the line D bits |
| up_line_vld | input | 1 | Upstream line D bits valid |
| up_line_d | input | 2 | Upstream line bits 7..6 |
| pcm_up_vld | input | 1 | Upstream PCM byte valid |
| pcm_up_slot | input | SLOT_W | Slot index of upstream PCM byte |
| pcm_up_in | input | 8 | Upstream PCM byte before insertion |
| pcm_up_out | output | 8 | Upstream PCM byte after insertion |
| pcm_up_out_vld | output | 1 | Upstream output byte valid |

## Verification
The assertions check the following on every cycle:
- States and selects hold between frame pulses.
- Each upstream byte appears one cycle later.
- The six unselected bits never change.
- A latched release code or unassigned code gives the right enable and idle value.

The bench scenarios show the rest:
- Every code position takes the right pair.
- A mismatched slot is ignored.
- Upstream data lands in the right position.
- A code change made between frame pulses has no effect.

// File: rtl/subslot_pkg.sv
package subslot_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] CODE_HIZ = 4'b1011;

    typedef enum logic [1:0] {DN_UNASG, DN_SWITCH, DN_HIZ} dn_state_t;
    typedef enum logic {UP_UNASG, UP_SWITCH} up_state_t;

    function automatic logic is_switch_code(input logic [3:0] code);
        return code[3:2] == 2'b01;
    endfunction

    function automatic logic [1:0] pick_pair(input logic [BYTE_W-1:0] b, input logic [1:0] sel);
        logic [BYTE_W-1:0] sh;
        sh = b >> {sel, 1'b0};
        return sh[1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] put_pair(input logic [BYTE_W-1:0] b,
                                                   input logic [1:0] pair,
                                                   input logic [1:0] sel);
        logic [BYTE_W-1:0] mask;
        logic [BYTE_W-1:0] ins;
        mask = {{(BYTE_W-2){1'b0}}, 2'b11} << {sel, 1'b0};
        ins  = {{(BYTE_W-2){1'b0}}, pair} << {sel, 1'b0};
        return (b & ~mask) | ins;
    endfunction
endpackage

// File: rtl/subslot_dn.sv
module subslot_dn
    import subslot_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic [3:0]        code_in,
    input  logic [SLOT_W-1:0] ptr_in,
    input  logic              pcm_vld,
    input  logic [SLOT_W-1:0] pcm_slot,
    input  logic [BYTE_W-1:0] pcm_byte,
    output logic [BYTE_W-1:0] line_byte,
    output logic              line_oe
);
    dn_state_t         state_q, state_d;
    logic [1:0]        sel_q;
    logic [SLOT_W-1:0] ptr_q;
    logic [1:0]        pair_q;

    always_comb begin
        state_d = state_q;
        if (frm_start) begin
            if (is_switch_code(code_in))  state_d = DN_SWITCH;
            else if (code_in == CODE_HIZ) state_d = DN_HIZ;
            else                          state_d = DN_UNASG;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DN_UNASG;
            sel_q   <= 2'b00;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (frm_start) begin
                sel_q <= code_in[1:0];
                ptr_q <= ptr_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pair_q <= 2'b11;
        else if (state_q == DN_SWITCH && pcm_vld && pcm_slot == ptr_q)
            pair_q <= pick_pair(pcm_byte, sel_q);
    end

    always_comb begin
        line_byte = '1;
        line_oe   = 1'b1;
        unique case (state_q)
            DN_SWITCH: line_byte[BYTE_W-1 -: 2] = pair_q;
            DN_HIZ:    line_oe = 1'b0;
            default:   line_oe = 1'b1;
        endcase
    end

    // R8: latched settings only move at a frame pulse
    a_r8_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_start |=> ($stable(state_q) && $stable(sel_q) && $stable(ptr_q)));
endmodule

// File: rtl/subslot_up.sv
module subslot_up
    import subslot_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic [3:0]        code_in,
    input  logic [SLOT_W-1:0] ptr_in,
    input  logic              line_vld,
    input  logic [1:0]        line_d,
    input  logic              pcm_vld,
    input  logic [SLOT_W-1:0] pcm_slot,
    input  logic [BYTE_W-1:0] pcm_in,
    output logic [BYTE_W-1:0] pcm_out,
    output logic              pcm_out_vld
);
    up_state_t         state_q, state_d;
    logic [1:0]        sel_q;
    logic [SLOT_W-1:0] ptr_q;
    logic [1:0]        pair_q;
    logic [BYTE_W-1:0] out_d;

    always_comb begin
        state_d = state_q;
        if (frm_start)
            state_d = is_switch_code(code_in) ? UP_SWITCH : UP_UNASG;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UP_UNASG;
            sel_q   <= 2'b00;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (frm_start) begin
                sel_q <= code_in[1:0];
                ptr_q <= ptr_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pair_q <= 2'b11;
        else if (state_q == UP_SWITCH && line_vld)
            pair_q <= line_d;
    end

    always_comb begin
        out_d = pcm_in;
        unique case (state_q)
            UP_SWITCH: if (pcm_slot == ptr_q) out_d = put_pair(pcm_in, pair_q, sel_q);
            default:   out_d = pcm_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcm_out     <= '0;
            pcm_out_vld <= 1'b0;
        end else begin
            pcm_out_vld <= pcm_vld;
            if (pcm_vld) pcm_out <= out_d;
        end
    end

    // R6: one-cycle latency on every valid byte
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_vld |=> pcm_out_vld);
    // R6: bits outside the selected pair are never altered
    a_r6_six_bits: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_vld |=> (((pcm_out ^ $past(pcm_in)) &
                      ~({{(BYTE_W-2){1'b0}}, 2'b11} << {$past(sel_q), 1'b0})) == '0));
    // R7: unassigned path is a pure pass-through
    a_r7_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_vld && state_q == UP_UNASG) |=> (pcm_out == $past(pcm_in)));
    // R8: latched settings only move at a frame pulse
    a_r8_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_start |=> ($stable(state_q) && $stable(sel_q) && $stable(ptr_q)));
endmodule

// File: rtl/subslot_switch.sv
module subslot_switch
    import subslot_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic [3:0]        dn_code,
    input  logic [SLOT_W-1:0] dn_ptr,
    input  logic [3:0]        up_code,
    input  logic [SLOT_W-1:0] up_ptr,
    input  logic              pcm_dn_vld,
    input  logic [SLOT_W-1:0] pcm_dn_slot,
    input  logic [7:0]        pcm_dn_byte,
    output logic [7:0]        dn_line_byte,
    output logic              dn_oe,
    input  logic              up_line_vld,
    input  logic [1:0]        up_line_d,
    input  logic              pcm_up_vld,
    input  logic [SLOT_W-1:0] pcm_up_slot,
    input  logic [7:0]        pcm_up_in,
    output logic [7:0]        pcm_up_out,
    output logic              pcm_up_out_vld
);
    subslot_dn #(.SLOT_W(SLOT_W)) u_dn (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start),
        .code_in(dn_code), .ptr_in(dn_ptr),
        .pcm_vld(pcm_dn_vld), .pcm_slot(pcm_dn_slot), .pcm_byte(pcm_dn_byte),
        .line_byte(dn_line_byte), .line_oe(dn_oe)
    );

    subslot_up #(.SLOT_W(SLOT_W)) u_up (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start),
        .code_in(up_code), .ptr_in(up_ptr),
        .line_vld(up_line_vld), .line_d(up_line_d),
        .pcm_vld(pcm_up_vld), .pcm_slot(pcm_up_slot), .pcm_in(pcm_up_in),
        .pcm_out(pcm_up_out), .pcm_out_vld(pcm_up_out_vld)
    );

    // R4: release code latched at a frame pulse disables the line driver
    a_r4_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start && dn_code == CODE_HIZ) |=> !dn_oe);
    // R5: unlisted downstream code gives idle ones with driver on
    a_r5_unasg: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start && !is_switch_code(dn_code) && dn_code != CODE_HIZ)
            |=> (dn_oe && dn_line_byte == 8'hFF));
endmodule

// File: tb/subslot_switch_tb.sv
module subslot_switch_tb;
    localparam int SLOT_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frm_start = 1'b0;
    logic [3:0]        dn_code = 4'b0000;
    logic [SLOT_W-1:0] dn_ptr = '0;
    logic [3:0]        up_code = 4'b0000;
    logic [SLOT_W-1:0] up_ptr = '0;
    logic              pcm_dn_vld = 1'b0;
    logic [SLOT_W-1:0] pcm_dn_slot = '0;
    logic [7:0]        pcm_dn_byte = '0;
    logic [7:0]        dn_line_byte;
    logic              dn_oe;
    logic              up_line_vld = 1'b0;
    logic [1:0]        up_line_d = '0;
    logic              pcm_up_vld = 1'b0;
    logic [SLOT_W-1:0] pcm_up_slot = '0;
    logic [7:0]        pcm_up_in = '0;
    logic [7:0]        pcm_up_out;
    logic              pcm_up_out_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    subslot_switch #(.SLOT_W(SLOT_W)) u_dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [3:0] dc, input logic [SLOT_W-1:0] dp,
                           input logic [3:0] uc, input logic [SLOT_W-1:0] up);
        @(negedge clk);
        dn_code = dc; dn_ptr = dp; up_code = uc; up_ptr = up;
        frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
    endtask

    task automatic send_dn(input logic [SLOT_W-1:0] s, input logic [7:0] b);
        pcm_dn_vld = 1'b1; pcm_dn_slot = s; pcm_dn_byte = b;
        @(negedge clk);
        pcm_dn_vld = 1'b0;
    endtask

    task automatic send_line(input logic [1:0] d);
        up_line_vld = 1'b1; up_line_d = d;
        @(negedge clk);
        up_line_vld = 1'b0;
    endtask

    task automatic send_up(input logic [SLOT_W-1:0] s, input logic [7:0] b,
                           input logic [7:0] exp, input string req);
        pcm_up_vld = 1'b1; pcm_up_slot = s; pcm_up_in = b;
        @(negedge clk);
        pcm_up_vld = 1'b0;
        chk(req, {7'd0, pcm_up_out_vld}, 8'd1);
        chk(req, pcm_up_out, exp);
    endtask

    task automatic t_reset();
        chk("R1 line byte", dn_line_byte, 8'hFF);
        chk("R1 oe", {7'd0, dn_oe}, 8'd1);
        chk("R1 up vld", {7'd0, pcm_up_out_vld}, 8'd0);
    endtask

    task automatic t_dn_positions();
        for (int p = 0; p < 4; p++) begin
            logic [7:0] shv;
            set_cfg({2'b01, 2'(p)}, 5'd5, 4'b0000, 5'd0);
            send_dn(5'd5, 8'hE4);
            shv = 8'hE4 >> (2 * p);
            chk("R2 pair", dn_line_byte, {shv[1:0], 6'h3F});
            chk("R2 oe", {7'd0, dn_oe}, 8'd1);
        end
    endtask

    task automatic t_dn_slotmatch();
        set_cfg(4'b0111, 5'd9, 4'b0000, 5'd0);
        send_dn(5'd9, 8'h80);
        chk("R3 matched", dn_line_byte, 8'hBF);
        send_dn(5'd8, 8'h40);
        chk("R3 other slot ignored", dn_line_byte, 8'hBF);
        send_dn(5'd9, 8'h40);
        chk("R3 matched again", dn_line_byte, 8'h7F);
    endtask

    task automatic t_dn_hiz();
        set_cfg(4'b1011, 5'd9, 4'b0000, 5'd0);
        chk("R4 oe low", {7'd0, dn_oe}, 8'd0);
    endtask

    task automatic t_dn_unasg();
        set_cfg(4'b1010, 5'd9, 4'b0000, 5'd0);
        chk("R5 oe 1010", {7'd0, dn_oe}, 8'd1);
        chk("R5 byte 1010", dn_line_byte, 8'hFF);
        set_cfg(4'b1111, 5'd9, 4'b0000, 5'd0);
        send_dn(5'd9, 8'h00);
        chk("R5 byte 1111", dn_line_byte, 8'hFF);
    endtask

    task automatic t_up_insert();
        set_cfg(4'b1010, 5'd0, 4'b0101, 5'd3);
        send_line(2'b10);
        send_up(5'd3, 8'h00, 8'h08, "R6 insert into zeros");
        send_up(5'd3, 8'hFF, 8'hFB, "R6 insert into ones");
        send_up(5'd4, 8'h5A, 8'h5A, "R6 other slot");
        set_cfg(4'b1010, 5'd0, 4'b0111, 5'd3);
        send_line(2'b01);
        send_up(5'd3, 8'hAA, 8'h6A, "R6 top pair");
    endtask

    task automatic t_up_unasg();
        set_cfg(4'b1010, 5'd0, 4'b0000, 5'd3);
        send_line(2'b00);
        send_up(5'd3, 8'h12, 8'h12, "R7 code 0000");
        set_cfg(4'b1010, 5'd0, 4'b1001, 5'd3);
        send_up(5'd3, 8'hC3, 8'hC3, "R7 code 1001");
    endtask

    task automatic t_cfg_timing();
        set_cfg(4'b0111, 5'd5, 4'b0100, 5'd2);
        send_line(2'b11);
        @(negedge clk);
        dn_code = 4'b1011; up_ptr = 5'd7;
        @(negedge clk);
        chk("R8 dn code held", {7'd0, dn_oe}, 8'd1);
        send_up(5'd7, 8'h00, 8'h00, "R8 new ptr not yet active");
        send_up(5'd2, 8'h00, 8'h03, "R8 old ptr still active");
        set_cfg(4'b1011, 5'd5, 4'b0100, 5'd7);
        chk("R8 dn code applied", {7'd0, dn_oe}, 8'd0);
        send_up(5'd7, 8'h00, 8'h03, "R8 new ptr active");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dn_positions();
        t_dn_slotmatch();
        t_dn_hiz();
        t_dn_unasg();
        t_up_insert();
        t_up_unasg();
        t_cfg_timing();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule